// File: doc/BRIEF.md
# Access Violation Error Capture

This block records the first denied access on each slave port of a memory protection unit. The region checker in front of it raises a one-cycle deny strobe for a port. With the strobe it supplies the master number, the full address, the direction, whether the access was an instruction fetch or a data access, whether the master was in user or supervisor mode, a process identifier and a hit classification. The block stores those details and raises a sticky per-port error flag. It then ignores later denials on that port until software clears the flag.

Software fetches the stored record with a one-cycle read strobe that names a port and one of two words. The address word returns the captured address. The detail word packs the remaining fields and the flag. Reads cannot be back-pressured: a read strobe may be issued on any cycle, and its answer appears, tagged by a valid pulse, exactly one cycle later. Clearing uses a write-one mask, so one write can release any set of ports. The permission decision and interrupt routing live elsewhere.

Top module: `avc_err_capture`

## Requirements
- R1: After reset every error flag is 0, and every read of a valid port returns 0 in both words.
- R2: A deny strobe on a port whose flag is 0 sets that port's flag on the next cycle and stores the details of that access. Other ports are not affected.
- R3: Detail word bits 1:0 hold the hit class as given (0 = no region hit, 1 = one non-overlapping region, 2 = overlapping regions). Bit 2 holds the access type (0 = read, 1 = write).
- R4: Detail word bits 4:3 hold the attribute: 0 = user instruction, 1 = user data, 2 = supervisor instruction, 3 = supervisor data.
- R5: Detail word bits 8+MW-1:8 hold the master number, and bits 23:16 hold the 8-bit process identifier. The address word (rd_sel = 0) returns the full captured address.
- R6: While a port's flag is 1, a deny strobe without a clear of that port leaves the flag set and the stored details unchanged.
- R7: A clear write (clr_wr = 1) drops to 0, on the next cycle, the flag of every port whose clr_mask bit is 1 and that has no deny on that cycle. Ports whose mask bit is 0 keep their flag and details. A deny on the cycle after the clear is captured.
- R8: A deny and a clear of the same port on the same cycle store the new access, and the flag stays 1.
- R9: rd_valid is 1 exactly on the cycle after each rd_req, and rd_data carries the selected word as it stood when the request was made.
- R10: A read naming a port index of NPORTS or above returns 0.
- R11: Detail word bit 31 reflects the port's flag, and bits 7:5, 15:8+MW and 30:24 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| deny_vld | input | NPORTS | Per-port deny strobe |
| deny_master | input | NPORTS*MW | Master number per port |
| deny_addr | input | NPORTS*AW | Access address per port |
| deny_write | input | NPORTS | 1 = write, 0 = read |
| deny_instr | input | NPORTS | 1 = instruction fetch, 0 = data |
| deny_user | input | NPORTS | 1 = user mode, 0 = supervisor |
| deny_pid | input | NPORTS*8 | Process identifier per port |
| deny_hit | input | NPORTS*2 | Hit classification per port |
| clr_wr | input | 1 | Clear write strobe |
| clr_mask | input | NPORTS | Write-one-to-clear mask |
| rd_req | input | 1 | Read strobe |
| rd_port | input | PSW | Port index to read |
| rd_sel | input | 1 | 0 = address word, 1 = detail word |
| rd_valid | output | 1 | Read answer valid |
| rd_data | output | RDW | Read answer |
| err_flags | output | NPORTS | Sticky per-port error flags |

## Verification
The bench builds the block with NPORTS = 6, MW = 4, AW = 32 and the process identifier kept. Six ports give a 3-bit port index, so the indices 6 and 7 can be read to exercise the out-of-range answer. Several ports can be hit at once with different hit classes and attributes. The 4-bit master field leaves unused detail bits whose zero value can be observed.

// File: rtl/avc_err_pkg.sv
package avc_err_pkg;
  typedef enum logic [1:0] {
    HIT_NONE    = 2'd0,
    HIT_SINGLE  = 2'd1,
    HIT_OVERLAP = 2'd2
  } hit_class_e;

  localparam int DET_HIT_LSB    = 0;
  localparam int DET_WR_BIT     = 2;
  localparam int DET_ATTR_LSB   = 3;
  localparam int DET_MASTER_LSB = 8;
  localparam int DET_PID_LSB    = 16;
  localparam int DET_FLAG_BIT   = 31;
  localparam int PID_BITS       = 8;

  function automatic logic [1:0] attr_code(input logic user, input logic instr);
    return {~user, ~instr};
  endfunction
endpackage

// File: rtl/avc_err_slot.sv
module avc_err_slot import avc_err_pkg::*; #(
  parameter int AW = 32,
  parameter int MW = 4,
  parameter bit HAS_PID = 1'b1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                deny,
  input  logic                clr,
  input  logic [MW-1:0]       in_master,
  input  logic [AW-1:0]       in_addr,
  input  logic                in_write,
  input  logic                in_instr,
  input  logic                in_user,
  input  logic [PID_BITS-1:0] in_pid,
  input  logic [1:0]          in_hit,
  output logic                flag,
  output logic [AW-1:0]       cap_addr,
  output logic [MW-1:0]       cap_master,
  output logic                cap_write,
  output logic [1:0]          cap_attr,
  output logic [PID_BITS-1:0] cap_pid,
  output logic [1:0]          cap_hit
);
  logic take;
  assign take = deny && (!flag || clr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag       <= 1'b0;
      cap_addr   <= '0;
      cap_master <= '0;
      cap_write  <= 1'b0;
      cap_attr   <= 2'd0;
      cap_hit    <= 2'd0;
    end else begin
      if (take) begin
        flag       <= 1'b1;
        cap_addr   <= in_addr;
        cap_master <= in_master;
        cap_write  <= in_write;
        cap_attr   <= attr_code(in_user, in_instr);
        cap_hit    <= in_hit;
      end else if (clr) begin
        flag <= 1'b0;
      end
    end
  end

  generate
    if (HAS_PID) begin : g_pid
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    cap_pid <= '0;
        else if (take) cap_pid <= in_pid;
      end
    end else begin : g_nopid
      assign cap_pid = '0;
    end
  endgenerate

  // R2
  first_err_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (deny && !flag) |=> flag);
  // R6
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && deny && !clr) |=> (flag && $stable(cap_addr) && $stable(cap_master)
                                && $stable(cap_hit) && $stable(cap_attr) && $stable(cap_write)));
  // R7
  clear_drops_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !deny) |=> !flag);
  // R8
  clear_with_deny_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && deny) |=> (flag && cap_addr == $past(in_addr)));
endmodule

// File: rtl/avc_err_readout.sv
module avc_err_readout import avc_err_pkg::*; #(
  parameter int NPORTS = 8,
  parameter int AW = 32,
  parameter int MW = 4,
  parameter int PSW = 3,
  parameter int RDW = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       rd_req,
  input  logic [PSW-1:0]             rd_port,
  input  logic                       rd_sel,
  input  logic [NPORTS-1:0]          flags,
  input  logic [NPORTS*AW-1:0]       addrs,
  input  logic [NPORTS*MW-1:0]       masters,
  input  logic [NPORTS-1:0]          writes,
  input  logic [NPORTS*2-1:0]        attrs,
  input  logic [NPORTS*PID_BITS-1:0] pids,
  input  logic [NPORTS*2-1:0]        hits,
  output logic                       rd_valid,
  output logic [RDW-1:0]             rd_data
);
  logic [RDW-1:0] word_d;
  logic [RDW-1:0] detail [NPORTS];

  for (genvar i = 0; i < NPORTS; i++) begin : g_det
    always_comb begin
      detail[i] = '0;
      detail[i][DET_HIT_LSB +: 2]        = hits[i*2 +: 2];
      detail[i][DET_WR_BIT]              = writes[i];
      detail[i][DET_ATTR_LSB +: 2]       = attrs[i*2 +: 2];
      detail[i][DET_MASTER_LSB +: MW]    = masters[i*MW +: MW];
      detail[i][DET_PID_LSB +: PID_BITS] = pids[i*PID_BITS +: PID_BITS];
      detail[i][DET_FLAG_BIT]            = flags[i];
    end
  end

  always_comb begin
    word_d = '0;
    for (int i = 0; i < NPORTS; i++) begin
      if (rd_port == PSW'(i)) begin
        if (rd_sel) word_d = detail[i];
        else        word_d = RDW'(addrs[i*AW +: AW]);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_req;
      if (rd_req) rd_data <= word_d;
    end
  end

  // R9
  read_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> rd_valid);
  // R9
  no_spurious_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> !rd_valid);
  // R10
  out_of_range_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && (32'(rd_port) >= NPORTS)) |=> (rd_data == '0));
endmodule

// File: rtl/avc_err_capture.sv
module avc_err_capture import avc_err_pkg::*; #(
  parameter int NPORTS = 8,
  parameter int AW = 32,
  parameter int MW = 4,
  parameter bit HAS_PID = 1'b1,
  localparam int PSW = (NPORTS > 1) ? $clog2(NPORTS) : 1,
  localparam int RDW = (AW > 32) ? AW : 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NPORTS-1:0]          deny_vld,
  input  logic [NPORTS*MW-1:0]       deny_master,
  input  logic [NPORTS*AW-1:0]       deny_addr,
  input  logic [NPORTS-1:0]          deny_write,
  input  logic [NPORTS-1:0]          deny_instr,
  input  logic [NPORTS-1:0]          deny_user,
  input  logic [NPORTS*PID_BITS-1:0] deny_pid,
  input  logic [NPORTS*2-1:0]        deny_hit,
  input  logic                       clr_wr,
  input  logic [NPORTS-1:0]          clr_mask,
  input  logic                       rd_req,
  input  logic [PSW-1:0]             rd_port,
  input  logic                       rd_sel,
  output logic                       rd_valid,
  output logic [RDW-1:0]             rd_data,
  output logic [NPORTS-1:0]          err_flags
);
  logic [NPORTS*AW-1:0]       s_addr;
  logic [NPORTS*MW-1:0]       s_master;
  logic [NPORTS-1:0]          s_write;
  logic [NPORTS*2-1:0]        s_attr;
  logic [NPORTS*PID_BITS-1:0] s_pid;
  logic [NPORTS*2-1:0]        s_hit;
  logic [NPORTS-1:0]          s_clr;

  assign s_clr = clr_wr ? clr_mask : '0;

  for (genvar p = 0; p < NPORTS; p++) begin : g_port
    avc_err_slot #(.AW(AW), .MW(MW), .HAS_PID(HAS_PID)) u_slot (
      .clk        (clk),
      .rst_n      (rst_n),
      .deny       (deny_vld[p]),
      .clr        (s_clr[p]),
      .in_master  (deny_master[p*MW +: MW]),
      .in_addr    (deny_addr[p*AW +: AW]),
      .in_write   (deny_write[p]),
      .in_instr   (deny_instr[p]),
      .in_user    (deny_user[p]),
      .in_pid     (deny_pid[p*PID_BITS +: PID_BITS]),
      .in_hit     (deny_hit[p*2 +: 2]),
      .flag       (err_flags[p]),
      .cap_addr   (s_addr[p*AW +: AW]),
      .cap_master (s_master[p*MW +: MW]),
      .cap_write  (s_write[p]),
      .cap_attr   (s_attr[p*2 +: 2]),
      .cap_pid    (s_pid[p*PID_BITS +: PID_BITS]),
      .cap_hit    (s_hit[p*2 +: 2])
    );
  end

  avc_err_readout #(.NPORTS(NPORTS), .AW(AW), .MW(MW), .PSW(PSW), .RDW(RDW)) u_readout (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_req   (rd_req),
    .rd_port  (rd_port),
    .rd_sel   (rd_sel),
    .flags    (err_flags),
    .addrs    (s_addr),
    .masters  (s_master),
    .writes   (s_write),
    .attrs    (s_attr),
    .pids     (s_pid),
    .hits     (s_hit),
    .rd_valid (rd_valid),
    .rd_data  (rd_data)
  );

  // R7
  unmasked_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr && (err_flags & ~clr_mask) != '0) |=> ((err_flags & $past(err_flags & ~clr_mask)) == $past(err_flags & ~clr_mask)));
endmodule

// File: tb/avc_err_capture_bench.sv
module avc_err_capture_bench;
  localparam int N = 6, AW = 32, MW = 4, PSW = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [N-1:0] deny_vld = '0, deny_write = '0, deny_instr = '0, deny_user = '0, clr_mask = '0;
  logic [N*MW-1:0] deny_master = '0;
  logic [N*AW-1:0] deny_addr = '0;
  logic [N*8-1:0] deny_pid = '0;
  logic [N*2-1:0] deny_hit = '0;
  logic clr_wr = 1'b0, rd_req = 1'b0, rd_sel = 1'b0;
  logic [PSW-1:0] rd_port = '0;
  logic rd_valid;
  logic [31:0] rd_data;
  logic [N-1:0] err_flags;

  always #2 clk = ~clk;

  avc_err_capture #(.NPORTS(N), .AW(AW), .MW(MW), .HAS_PID(1'b1)) u_avc_err_capture (
    .clk(clk), .rst_n(rst_n), .deny_vld(deny_vld), .deny_master(deny_master),
    .deny_addr(deny_addr), .deny_write(deny_write), .deny_instr(deny_instr),
    .deny_user(deny_user), .deny_pid(deny_pid), .deny_hit(deny_hit),
    .clr_wr(clr_wr), .clr_mask(clr_mask), .rd_req(rd_req), .rd_port(rd_port),
    .rd_sel(rd_sel), .rd_valid(rd_valid), .rd_data(rd_data), .err_flags(err_flags));

  // behavioural reference
  bit          m_flag [N];
  logic [31:0] m_addr [N];
  logic [31:0] m_det  [N];
  bit          m_vld;
  logic [31:0] m_rd;
  int checks = 0, fails = 0;
  string cur_req = "R1";
  bit done = 0;

  function automatic logic [31:0] ref_detail(int p);
    logic [31:0] w;
    w = m_det[p];
    if (m_flag[p]) w = w | 32'h8000_0000;
    return w;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int p = 0; p < N; p++) begin m_flag[p] = 0; m_addr[p] = 0; m_det[p] = 0; end
      m_vld = 0; m_rd = 0;
    end else begin
      m_vld = rd_req;
      if (rd_req) begin
        if (rd_port >= N) m_rd = 0;
        else if (rd_sel) m_rd = ref_detail(rd_port);
        else m_rd = m_addr[rd_port];
      end
      for (int p = 0; p < N; p++) begin
        bit c;
        c = clr_wr && clr_mask[p];
        if (deny_vld[p] && (!m_flag[p] || c)) begin
          int at;
          if (deny_user[p]) at = deny_instr[p] ? 0 : 1;
          else              at = deny_instr[p] ? 2 : 3;
          m_flag[p] = 1;
          m_addr[p] = deny_addr[p*AW +: AW];
          m_det[p]  = (32'(deny_pid[p*8 +: 8]) << 16) | (32'(deny_master[p*MW +: MW]) << 8)
                    | (32'(at) << 3) | (32'(deny_write[p]) << 2) | 32'(deny_hit[p*2 +: 2]);
        end else if (c) m_flag[p] = 0;
      end
    end
  end

  always @(negedge clk) if (rst_n && !done) begin
    logic [N-1:0] ef;
    for (int p = 0; p < N; p++) ef[p] = m_flag[p];
    checks++;
    if (err_flags !== ef) begin
      fails++; $display("FAIL %s flags act=%h exp=%h", cur_req, err_flags, ef);
    end
    checks++;
    if (rd_valid !== m_vld) begin
      fails++; $display("FAIL R9 rd_valid act=%b exp=%b", rd_valid, m_vld);
    end
    if (m_vld) begin
      checks++;
      if (rd_data !== m_rd) begin
        fails++; $display("FAIL %s rd_data act=%h exp=%h", cur_req, rd_data, m_rd);
      end
    end
  end

  task automatic tick();
    @(negedge clk);
    deny_vld = '0; clr_wr = 0; clr_mask = '0; rd_req = 0;
  endtask

  task automatic deny(int p, logic [3:0] mst, logic [31:0] a, bit wr, bit ins, bit usr,
                      logic [7:0] pid, logic [1:0] hit);
    deny_vld[p] = 1; deny_master[p*MW +: MW] = mst; deny_addr[p*AW +: AW] = a;
    deny_write[p] = wr; deny_instr[p] = ins; deny_user[p] = usr;
    deny_pid[p*8 +: 8] = pid; deny_hit[p*2 +: 2] = hit;
  endtask

  task automatic rd(int p, bit sel);
    rd_req = 1; rd_port = PSW'(p); rd_sel = sel; tick();
  endtask

  task automatic read_all(int p);
    rd(p, 0); rd(p, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    cur_req = "R1"; read_all(0); read_all(5);
    // R2 R3 R4 R5: write, single region, user data
    cur_req = "R2"; deny(2, 4'd5, 32'hDEAD_BEE0, 1, 0, 1, 8'h3C, 2'd1); tick();
    cur_req = "R5"; read_all(2); read_all(1);
    // R6: second deny on a flagged port is ignored
    cur_req = "R6"; deny(2, 4'd9, 32'h1111_2222, 0, 1, 0, 8'h77, 2'd2); tick(); read_all(2);
    // R3 R4: two ports at once, other classes and attributes
    cur_req = "R3"; deny(0, 4'd1, 32'h0000_1000, 0, 1, 1, 8'hA5, 2'd0);
    deny(4, 4'd15, 32'hFFFF_FFFF, 1, 1, 0, 8'hFF, 2'd2); tick();
    cur_req = "R4"; read_all(0); read_all(4);
    deny(3, 4'd7, 32'h8000_0004, 0, 0, 0, 8'h01, 2'd1); tick(); read_all(3);
    // R7: clear port 2 only, then re-arm next cycle
    cur_req = "R7"; clr_wr = 1; clr_mask = 6'b000100; tick(); read_all(2); read_all(0);
    deny(2, 4'd2, 32'h0BAD_F00D, 0, 1, 1, 8'h10, 2'd0); tick(); read_all(2);
    clr_mask = 6'b111111; tick(); read_all(3);
    // R8: deny and clear together
    cur_req = "R8"; deny(4, 4'd3, 32'h5555_AAAA, 0, 0, 1, 8'h42, 2'd1);
    clr_wr = 1; clr_mask = 6'b010001; tick(); read_all(4); read_all(0);
    // R10: indices beyond the port count
    cur_req = "R10"; read_all(6); read_all(7);
    // R9 R11: back-to-back reads of detail words with flags both ways
    cur_req = "R11"; rd(4, 1); rd(0, 1); rd(2, 1); rd(1, 1);
    clr_wr = 1; clr_mask = 6'b111111; tick(); read_all(4);
    cur_req = "R9"; rd(5, 0); tick(); tick();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1; fails++;
      $display("FAIL watchdog act=running exp=finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule